// File: doc/BRIEF.md
# Frame Fetch Sequencer with Palette Header Decode

This block runs the fetch of one display frame from a linear frame buffer in memory. When a frame is requested it can first read a 256-word palette header through a simple word-read port and stream each entry out. Bits of the first entry give the pixel depth. From that depth the block works out where pixel data starts and the length of one line in bytes. It then checks that the whole frame fits inside the configured buffer, with two bytes of slack. If it fits, it issues one start address per display line to a downstream pixel fetcher.

Two buffers can be used in turn (ping-pong). After each started frame the block records a per-buffer condition bit. A line window can either move the first line fetched or cut the line count. Three palette modes are supported: palette and data, palette only, and data only. A frame that does not fit raises a sync error and drops the block's active state. The block then stays idle until `run` is taken low and high again.

Top module: `lcd_frame_fetch`

## Requirements
- R1: In palette modes (`cfg_pal_mode` 0, 1 or 3), a frame reads 256 consecutive 16-bit entries starting at the current buffer's top address, and each read shows up as one `pal_we` pulse. In data-only mode (`cfg_pal_mode` = 2) no memory read is made.
- R2: Bits 14:12 of palette entry 0 form the depth code. Code 1 gives 2 bpp, 2 gives 4 bpp, 3 gives 8 bpp, and 4 to 7 give 16 bpp, shown on `depth_code` and `pix_bpp`. Code 0 produces no `frame_start` and no lines, but `frame_done` still pulses.
- R3: Pixel data starts 0x200 bytes past the buffer top for codes 3 to 7, 0x20 bytes past it for codes 1 and 2, and at the top itself in data-only mode. Data-only mode reuses the last decoded code.
- R4: If offset + width*height*bpp/8 is greater than (bottom − top) + 2, `sync_err` pulses, `active` falls and no line is issued. An exact fit at that limit is accepted. While inactive, `frame_go` is ignored until `run` goes low and then high.
- R5: `palette_done` pulses after the first complete palette read following each rise of `run`, and not for later frames under the same enable.
- R6: In palette-only mode (`cfg_pal_mode` = 1) the palette is read, then `frame_done` pulses with no `frame_start` and no lines.
- R7: Each `frame_start` sets bit `buf_sel` of `cond_bits`. With `cfg_dual` high, `buf_sel` toggles after each started frame. A rise of `run` clears `cond_bits` and selects buffer 0.
- R8: `line_bytes` = width*bpp/8 (width = `cfg_width_m1`+1). Line n is issued at top + offset + n*`line_bytes`, with `line_idx` = n.
- R9: With `cfg_win_en` high and `cfg_win_first` high, `cfg_win_field` is the first line and the count is `cfg_height_m1`+1. With `cfg_win_en` high and `cfg_win_first` low, lines 0 up to `cfg_win_field`−1 are issued. With `cfg_win_en` low, the window inputs have no effect.
- R10: `fmt16` is high when the depth code is 4 to 7 and `cfg_tft` is high, and low otherwise.
- R11: A line is issued only in a cycle after `line_rdy` was sampled high. Stalls drop or reorder no line, and `frame_done` follows the last line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enable level; a rising edge starts a new enable period |
| frame_go | input | 1 | Pulse requesting one frame |
| cfg_width_m1 | input | LW | Width in pixels minus one |
| cfg_height_m1 | input | LW | Height in lines minus one |
| cfg_pal_mode | input | 2 | 1 palette only, 2 data only, else both |
| cfg_win_en | input | 1 | Line window enable |
| cfg_win_first | input | 1 | Window field is first line (1) or line count (0) |
| cfg_win_field | input | LW | Window line value |
| cfg_dual | input | 1 | Ping-pong between two buffers |
| cfg_tft | input | 1 | Panel type for the 16 bpp colour format |
| buf0_top | input | AW | Buffer 0 start byte address |
| buf0_bot | input | AW | Buffer 0 end byte address |
| buf1_top | input | AW | Buffer 1 start byte address |
| buf1_bot | input | AW | Buffer 1 end byte address |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | AW | Read byte address |
| mem_ack | input | 1 | Read acknowledge, data valid the same cycle |
| mem_rdata | input | 16 | Read data |
| pal_we | output | 1 | Palette entry valid |
| pal_idx | output | 8 | Palette entry index |
| pal_data | output | 16 | Palette entry value |
| line_rdy | input | 1 | Downstream accepts a line address |
| line_valid | output | 1 | Line address valid for one cycle |
| line_addr | output | AW | Line start byte address |
| line_idx | output | LW | Line number |
| line_bytes | output | LW+2 | Bytes per line |
| depth_code | output | 3 | Decoded depth code |
| pix_bpp | output | 5 | Bits per pixel |
| fmt16 | output | 1 | 16-bit colour format selected |
| active | output | 1 | Block enabled and not stopped by a sync error |
| buf_sel | output | 1 | Current buffer index |
| cond_bits | output | 2 | Per-buffer frame-started flags |
| palette_done | output | 1 | First palette load of the enable period finished |
| frame_start | output | 1 | Frame accepted, lines follow |
| frame_done | output | 1 | Frame sequence finished |
| sync_err | output | 1 | Frame does not fit the buffer |

## Verification
The bench aims at the fit limit from both sides. A check one byte too strict would reject the exact-fit frame, and a check missing the two-byte slack or the header offset would accept the oversize one. It switches between the short and long header offsets and the data-only mode. Here an offset decoded from the wrong code, or a read made in data-only mode, shows up as wrong line addresses or a nonzero palette count. It runs two enable periods with ping-pong, the line window in both meanings and with its enable off, and stalls from downstream. These expose a buffer index that does not toggle or reset, a `palette_done` repeated within one enable, a window that ignores its enable bit, and lines lost or reordered under back-pressure.

// File: rtl/lcd_fetch_pkg.sv
package lcd_fetch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAL,
    ST_CHECK,
    ST_LINES,
    ST_DONE
  } fetch_state_t;

  localparam logic [1:0] PM_PAL_ONLY  = 2'd1;
  localparam logic [1:0] PM_DATA_ONLY = 2'd2;

  // depth code from header entry 0 to bits per pixel; 0 means unsupported
  function automatic logic [4:0] code_to_bpp(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd0;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/lcd_pal_reader.sv
module lcd_pal_reader #(
  parameter int AW      = 24,
  parameter int ENTRIES = 256,
  parameter int DW      = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       abort,
  input  logic [AW-1:0]              base,
  output logic                       mem_req,
  output logic [AW-1:0]              mem_addr,
  input  logic                       mem_ack,
  input  logic [DW-1:0]              mem_rdata,
  output logic                       ent_we,
  output logic [$clog2(ENTRIES)-1:0] ent_idx,
  output logic [DW-1:0]              ent_data,
  output logic [2:0]                 hdr_code,
  output logic                       fin
);
  localparam int IW = $clog2(ENTRIES);
  localparam int EB = DW / 8;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic          busy;
  logic [IW-1:0] idx;
  logic [AW-1:0] base_q;

  assign mem_req  = busy;
  assign mem_addr = base_q + AW'(idx) * AW'(EB);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      idx      <= '0;
      base_q   <= '0;
      ent_we   <= 1'b0;
      ent_idx  <= '0;
      ent_data <= '0;
      hdr_code <= '0;
      fin      <= 1'b0;
    end else begin
      ent_we <= 1'b0;
      fin    <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (start) begin
        busy   <= 1'b1;
        idx    <= '0;
        base_q <= base;
      end else if (busy && mem_ack) begin
        ent_we   <= 1'b1;
        ent_idx  <= idx;
        ent_data <= mem_rdata;
        if (idx == '0) hdr_code <= mem_rdata[14:12];
        if (idx == LAST) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R1
  pal_last_idx_chk: assert property (@(posedge clk) disable iff (rst)
    fin |-> (ent_we && ent_idx == LAST));

endmodule

// File: rtl/lcd_size_check.sv
module lcd_size_check
  import lcd_fetch_pkg::*;
#(
  parameter int AW          = 24,
  parameter int LW          = 10,
  parameter int PAL_BYTES   = 512,
  parameter int SHORT_BYTES = 32
) (
  input  logic [LW-1:0]   width_m1,
  input  logic [LW-1:0]   height_m1,
  input  logic [2:0]      code,
  input  logic            has_pal,
  input  logic [AW-1:0]   top,
  input  logic [AW-1:0]   bot,
  output logic [LW+1:0]   stride,
  output logic [AW-1:0]   data_off,
  output logic            fits
);
  localparam int SW = LW + 2;
  localparam int NB = 2 * LW + 2;
  localparam int CW = ((AW > NB) ? AW : NB) + 2;

  logic [LW:0]   w_px;
  logic [LW:0]   h_ln;
  logic [4:0]    bpp;
  logic [LW+5:0] row_bits;
  logic [CW-1:0] area_bits;
  logic [CW-1:0] need;

  assign w_px = {1'b0, width_m1} + (LW+1)'(1);
  assign h_ln = {1'b0, height_m1} + (LW+1)'(1);
  assign bpp  = code_to_bpp(code);

  assign row_bits = (LW+6)'(w_px) * (LW+6)'(bpp);
  assign stride   = SW'(row_bits >> 3);

  always_comb begin
    if (!has_pal)          data_off = '0;
    else if (code >= 3'd3) data_off = AW'(PAL_BYTES);
    else                   data_off = AW'(SHORT_BYTES);
  end

  assign area_bits = CW'(w_px) * CW'(h_ln) * CW'(bpp);
  assign need      = (area_bits >> 3) + CW'(data_off);
  assign fits      = (CW'(top) + need) <= (CW'(bot) + CW'(2));

endmodule

// File: rtl/lcd_line_gen.sv
module lcd_line_gen #(
  parameter int AW = 24,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          abort,
  input  logic [AW-1:0] base,
  input  logic [LW+1:0] stride,
  input  logic [LW-1:0] first,
  input  logic [LW:0]   count,
  input  logic          rdy,
  output logic          line_valid,
  output logic [AW-1:0] line_addr,
  output logic [LW-1:0] line_idx,
  output logic          fin
);
  logic          busy;
  logic [AW-1:0] nxt_addr;
  logic [LW:0]   cur;
  logic [LW:0]   lim;
  logic [LW+1:0] stride_q;
  logic          has_lines;

  assign has_lines = {1'b0, first} < count;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      nxt_addr   <= '0;
      cur        <= '0;
      lim        <= '0;
      stride_q   <= '0;
      line_valid <= 1'b0;
      line_addr  <= '0;
      line_idx   <= '0;
      fin        <= 1'b0;
    end else begin
      line_valid <= 1'b0;
      fin        <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (load) begin
        nxt_addr <= base + AW'(stride) * AW'(first);
        cur      <= {1'b0, first};
        lim      <= count;
        stride_q <= stride;
        busy     <= has_lines;
        fin      <= !has_lines;
      end else if (busy && rdy) begin
        line_valid <= 1'b1;
        line_addr  <= nxt_addr;
        line_idx   <= cur[LW-1:0];
        nxt_addr   <= nxt_addr + AW'(stride_q);
        cur        <= cur + 1'b1;
        if (cur + 1'b1 >= lim) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  // R8
  line_step_chk: assert property (@(posedge clk) disable iff (rst)
    (line_valid && $past(line_valid)) |->
      (line_addr == $past(line_addr) + AW'(stride_q) && line_idx == $past(line_idx) + 1'b1));

endmodule

// File: rtl/lcd_frame_fetch.sv
module lcd_frame_fetch
  import lcd_fetch_pkg::*;
#(
  parameter int AW          = 24,
  parameter int LW          = 10,
  parameter int PAL_ENTRIES = 256,
  parameter int SHORT_BYTES = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           run,
  input  logic                           frame_go,
  input  logic [LW-1:0]                  cfg_width_m1,
  input  logic [LW-1:0]                  cfg_height_m1,
  input  logic [1:0]                     cfg_pal_mode,
  input  logic                           cfg_win_en,
  input  logic                           cfg_win_first,
  input  logic [LW-1:0]                  cfg_win_field,
  input  logic                           cfg_dual,
  input  logic                           cfg_tft,
  input  logic [AW-1:0]                  buf0_top,
  input  logic [AW-1:0]                  buf0_bot,
  input  logic [AW-1:0]                  buf1_top,
  input  logic [AW-1:0]                  buf1_bot,
  output logic                           mem_req,
  output logic [AW-1:0]                  mem_addr,
  input  logic                           mem_ack,
  input  logic [15:0]                    mem_rdata,
  output logic                           pal_we,
  output logic [$clog2(PAL_ENTRIES)-1:0] pal_idx,
  output logic [15:0]                    pal_data,
  input  logic                           line_rdy,
  output logic                           line_valid,
  output logic [AW-1:0]                  line_addr,
  output logic [LW-1:0]                  line_idx,
  output logic [LW+1:0]                  line_bytes,
  output logic [2:0]                     depth_code,
  output logic [4:0]                     pix_bpp,
  output logic                           fmt16,
  output logic                           active,
  output logic                           buf_sel,
  output logic [1:0]                     cond_bits,
  output logic                           palette_done,
  output logic                           frame_start,
  output logic                           frame_done,
  output logic                           sync_err
);
  localparam int PAL_BYTES = PAL_ENTRIES * 2;

  fetch_state_t  state;
  logic          run_q;
  logic          run_rise;
  logic          pal_loaded;
  logic          pal_start;
  logic          pal_fin;
  logic          has_pal;
  logic          chk_go;
  logic          chk_pass;
  logic          chk_fail;
  logic          lg_fin;
  logic [AW-1:0] top_sel;
  logic [AW-1:0] bot_sel;
  logic [LW+1:0] stride;
  logic [AW-1:0] data_off;
  logic          fits;
  logic [LW-1:0] first_ln;
  logic [LW:0]   count_ln;

  assign run_rise = run && !run_q;
  assign has_pal  = (cfg_pal_mode != PM_DATA_ONLY);
  assign top_sel  = buf_sel ? buf1_top : buf0_top;
  assign bot_sel  = buf_sel ? buf1_bot : buf0_bot;

  assign pal_start = (state == ST_IDLE) && active && frame_go && has_pal;
  assign chk_go    = (state == ST_CHECK) && active && (depth_code != 3'd0);
  assign chk_pass  = chk_go && fits;
  assign chk_fail  = chk_go && !fits;

  always_comb begin
    first_ln = '0;
    count_ln = {1'b0, cfg_height_m1} + (LW+1)'(1);
    if (cfg_win_en) begin
      if (cfg_win_first) first_ln = cfg_win_field;
      else               count_ln = {1'b0, cfg_win_field};
    end
  end

  lcd_pal_reader #(.AW(AW), .ENTRIES(PAL_ENTRIES), .DW(16)) u_pal (
    .clk       (clk),
    .rst       (rst),
    .start     (pal_start),
    .abort     (!active),
    .base      (top_sel),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .ent_we    (pal_we),
    .ent_idx   (pal_idx),
    .ent_data  (pal_data),
    .hdr_code  (depth_code),
    .fin       (pal_fin)
  );

  lcd_size_check #(.AW(AW), .LW(LW), .PAL_BYTES(PAL_BYTES), .SHORT_BYTES(SHORT_BYTES)) u_size (
    .width_m1  (cfg_width_m1),
    .height_m1 (cfg_height_m1),
    .code      (depth_code),
    .has_pal   (has_pal),
    .top       (top_sel),
    .bot       (bot_sel),
    .stride    (stride),
    .data_off  (data_off),
    .fits      (fits)
  );

  lcd_line_gen #(.AW(AW), .LW(LW)) u_lines (
    .clk        (clk),
    .rst        (rst),
    .load       (chk_pass),
    .abort      (!active),
    .base       (top_sel + data_off),
    .stride     (stride),
    .first      (first_ln),
    .count      (count_ln),
    .rdy        (line_rdy),
    .line_valid (line_valid),
    .line_addr  (line_addr),
    .line_idx   (line_idx),
    .fin        (lg_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      run_q        <= 1'b0;
      active       <= 1'b0;
      pal_loaded   <= 1'b0;
      buf_sel      <= 1'b0;
      cond_bits    <= '0;
      line_bytes   <= '0;
      pix_bpp      <= '0;
      fmt16        <= 1'b0;
      palette_done <= 1'b0;
      frame_start  <= 1'b0;
      frame_done   <= 1'b0;
      sync_err     <= 1'b0;
    end else begin
      run_q        <= run;
      palette_done <= 1'b0;
      frame_start  <= 1'b0;
      frame_done   <= 1'b0;
      sync_err     <= 1'b0;
      pix_bpp      <= code_to_bpp(depth_code);
      fmt16        <= cfg_tft && (depth_code >= 3'd4);

      if (!run)          active <= 1'b0;
      else if (run_rise) active <= 1'b1;
      else if (chk_fail) active <= 1'b0;

      if (!active && state != ST_IDLE) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (active && frame_go) state <= has_pal ? ST_PAL : ST_CHECK;
          end
          ST_PAL: begin
            if (pal_fin) begin
              if (!pal_loaded) palette_done <= 1'b1;
              pal_loaded <= 1'b1;
              state <= (cfg_pal_mode == PM_PAL_ONLY) ? ST_DONE : ST_CHECK;
            end
          end
          ST_CHECK: begin
            if (depth_code == 3'd0) begin
              state <= ST_DONE;
            end else if (!fits) begin
              sync_err <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              frame_start        <= 1'b1;
              cond_bits[buf_sel] <= 1'b1;
              if (cfg_dual) buf_sel <= !buf_sel;
              line_bytes <= stride;
              state      <= ST_LINES;
            end
          end
          ST_LINES: begin
            if (lg_fin) state <= ST_DONE;
          end
          ST_DONE: begin
            frame_done <= 1'b1;
            state      <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end

      if (run_rise) begin
        pal_loaded <= 1'b0;
        buf_sel    <= 1'b0;
        cond_bits  <= '0;
      end
    end
  end

  // R4
  sync_drop_chk: assert property (@(posedge clk) disable iff (rst)
    sync_err |-> !active);

  // R7
  start_excl_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (!sync_err && !frame_done));

  // R7
  cond_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && $past(run_q)) |-> ((cond_bits & $past(cond_bits)) == $past(cond_bits)));

  // R11
  line_in_lines_chk: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> ($past(state) == ST_LINES));

endmodule

// File: tb/lcd_frame_fetch_test.sv
module lcd_frame_fetch_test;
  localparam int AW = 24;
  localparam int LW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          run = 0, frame_go = 0;
  logic [LW-1:0] cfg_width_m1 = 0, cfg_height_m1 = 0, cfg_win_field = 0;
  logic [1:0]    cfg_pal_mode = 0;
  logic          cfg_win_en = 0, cfg_win_first = 0, cfg_dual = 0, cfg_tft = 0;
  logic [AW-1:0] buf0_top = 24'h1000, buf0_bot = 24'h1240;
  logic [AW-1:0] buf1_top = 24'h4000, buf1_bot = 24'h4240;
  logic          mem_req, mem_ack, pal_we, line_valid, fmt16, active, buf_sel;
  logic [AW-1:0] mem_addr, line_addr;
  logic [15:0]   mem_rdata, pal_data;
  logic [7:0]    pal_idx;
  logic [LW-1:0] line_idx;
  logic [LW+1:0] line_bytes;
  logic [2:0]    depth_code;
  logic [4:0]    pix_bpp;
  logic [1:0]    cond_bits;
  logic          palette_done, frame_start, frame_done, sync_err;
  logic          line_rdy;

  logic [2:0]    hdr_code = 3'd3;
  logic          ack_gate = 1'b0;
  logic          stall_on = 1'b0;
  int unsigned   cyc = 0;

  always @(posedge clk) begin
    ack_gate <= ~ack_gate;
    cyc      <= cyc + 1;
  end
  assign mem_ack   = mem_req && ack_gate;
  assign mem_rdata = (mem_addr[8:0] == 9'd0) ? {1'b0, hdr_code, 12'h000} : mem_addr[16:1];
  assign line_rdy  = stall_on ? ((cyc % 3) != 0) : 1'b1;

  lcd_frame_fetch #(.AW(AW), .LW(LW)) uut (.*);

  int n_chk = 0, n_fail = 0;
  int n_pal = 0, n_pd = 0, n_fs = 0, n_fd = 0, n_se = 0;
  logic [AW+LW-1:0] exp_q[$];
  string line_tag = "R8";

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (pal_we) n_pal++;
      if (palette_done) n_pd++;
      if (frame_start) n_fs++;
      if (frame_done) n_fd++;
      if (sync_err) n_se++;
      if (line_valid) begin
        if (exp_q.size() == 0) chk(1'b0, {line_tag, " unexpected line"}, line_addr, 0);
        else begin
          logic [AW+LW-1:0] e;
          e = exp_q.pop_front();
          chk({line_addr, line_idx} == e, {line_tag, " line addr/idx"}, {line_addr, line_idx}, e);
        end
      end
    end
  end

  task automatic set_run(input logic v);
    @(posedge clk); #1 run = v;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic setup(input int w, input int h, input logic [1:0] mode, input logic [2:0] code);
    cfg_width_m1  = LW'(w - 1);
    cfg_height_m1 = LW'(h - 1);
    cfg_pal_mode  = mode;
    hdr_code      = code;
  endtask

  task automatic push_lines(input int base, input int stride, input int first, input int count);
    for (int i = first; i < count; i++) exp_q.push_back({AW'(base + stride * i), LW'(i)});
  endtask

  task automatic go_frame(input int limit);
    n_pal = 0; n_pd = 0; n_fs = 0; n_fd = 0; n_se = 0;
    @(posedge clk); #1 frame_go = 1;
    @(posedge clk); #1 frame_go = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (n_fd != 0 || n_se != 0) break;
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic end_lines(input string tag);
    chk(exp_q.size() == 0, {tag, " missing lines"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!line_valid && !mem_req && !pal_we, "R11 reset outputs quiet", {line_valid, mem_req, pal_we}, 0);
    chk(!active, "R4 reset inactive", active, 0);
    chk(cond_bits == 0 && !buf_sel, "R7 reset cond/buf", {cond_bits, buf_sel}, 0);

    // basic 8 bpp frame, exact fit at the slack limit
    set_run(1);
    setup(16, 4, 2'd0, 3'd3);
    buf0_bot = 24'h123e;
    push_lines(24'h1200, 16, 0, 4);
    go_frame(3000);
    end_lines("R8");
    chk(n_pal == 256, "R1 palette entries", n_pal, 256);
    chk(n_pd == 1, "R5 palette_done first frame", n_pd, 1);
    chk(n_se == 0 && n_fs == 1, "R4 exact fit accepted", n_se, 0);
    chk(cond_bits == 2'b01, "R7 cond after frame", cond_bits, 1);
    chk(line_bytes == 16, "R8 line bytes", line_bytes, 16);
    chk(pix_bpp == 8 && depth_code == 3, "R2 8 bpp decode", pix_bpp, 8);
    chk(n_fd == 1, "R11 frame_done after lines", n_fd, 1);

    // second frame same enable
    push_lines(24'h1200, 16, 0, 4);
    go_frame(3000);
    end_lines("R8");
    chk(n_pd == 0, "R5 no second palette_done", n_pd, 0);
    chk(n_pal == 256, "R1 palette read again", n_pal, 256);

    // ping-pong
    set_run(0); set_run(1);
    chk(cond_bits == 0 && !buf_sel, "R7 cleared on enable", {cond_bits, buf_sel}, 0);
    cfg_dual = 1;
    push_lines(24'h1200, 16, 0, 4);
    go_frame(3000);
    end_lines("R7");
    chk(n_pd == 1, "R5 palette_done new enable", n_pd, 1);
    chk(cond_bits == 2'b01 && buf_sel, "R7 first buffer used", {cond_bits, buf_sel}, 3'b011);
    push_lines(24'h4200, 16, 0, 4);
    go_frame(3000);
    end_lines("R7");
    chk(cond_bits == 2'b11 && !buf_sel, "R7 second buffer used", {cond_bits, buf_sel}, 3'b110);
    cfg_dual = 0;

    // 2 bpp and 4 bpp, short header
    buf0_bot = 24'h2000;
    setup(32, 2, 2'd0, 3'd1);
    push_lines(24'h1020, 8, 0, 2);
    go_frame(3000);
    end_lines("R3");
    chk(pix_bpp == 2 && line_bytes == 8, "R2 2 bpp", {pix_bpp, line_bytes}, {5'd2, 12'd8});
    setup(16, 2, 2'd0, 3'd2);
    push_lines(24'h1020, 8, 0, 2);
    go_frame(3000);
    end_lines("R3");
    chk(pix_bpp == 4, "R2 4 bpp", pix_bpp, 4);

    // 16 bpp, both panel types
    cfg_tft = 1;
    setup(8, 3, 2'd0, 3'd5);
    push_lines(24'h1200, 16, 0, 3);
    go_frame(3000);
    end_lines("R2");
    chk(pix_bpp == 16 && fmt16, "R10 16 bpp tft format", {pix_bpp, fmt16}, {5'd16, 1'b1});
    cfg_tft = 0;
    push_lines(24'h1200, 16, 0, 3);
    go_frame(3000);
    end_lines("R10");
    chk(!fmt16, "R10 16 bpp stn format", fmt16, 0);

    // unsupported code
    setup(16, 4, 2'd0, 3'd0);
    go_frame(3000);
    end_lines("R2");
    chk(n_fs == 0 && n_fd == 1, "R2 code 0 skips frame", {n_fs, n_fd}, 1);

    // oversize by one byte
    setup(16, 4, 2'd0, 3'd3);
    buf0_bot = 24'h123d;
    go_frame(3000);
    end_lines("R4");
    chk(n_se == 1 && n_fs == 0, "R4 sync error raised", n_se, 1);
    chk(!active, "R4 active dropped", active, 0);
    go_frame(600);
    chk(n_pal == 0 && n_fd == 0, "R4 frame_go ignored while stopped", n_pal, 0);

    // data-only mode keeps last code, no reads
    set_run(0); set_run(1);
    buf0_bot = 24'h2000;
    setup(16, 4, 2'd2, 3'd1);
    push_lines(24'h1000, 16, 0, 4);
    go_frame(3000);
    end_lines("R3");
    chk(n_pal == 0, "R1 no reads in data-only", n_pal, 0);
    chk(n_pd == 0, "R5 no palette_done in data-only", n_pd, 0);

    // palette-only
    setup(16, 4, 2'd1, 3'd3);
    go_frame(3000);
    end_lines("R6");
    chk(n_pal == 256 && n_fs == 0 && n_fd == 1, "R6 palette only", {n_pal, n_fs, n_fd}, {256, 0, 1});

    // line window
    setup(16, 4, 2'd0, 3'd3);
    line_tag = "R9";
    cfg_win_en = 1; cfg_win_first = 1; cfg_win_field = 2;
    push_lines(24'h1200, 16, 2, 4);
    go_frame(3000);
    end_lines("R9");
    cfg_win_first = 0; cfg_win_field = 1;
    push_lines(24'h1200, 16, 0, 1);
    go_frame(3000);
    end_lines("R9");
    cfg_win_en = 0; cfg_win_first = 1; cfg_win_field = 2;
    push_lines(24'h1200, 16, 0, 4);
    go_frame(3000);
    end_lines("R9");
    chk(n_fd == 1, "R9 window disabled frame done", n_fd, 1);

    // downstream stalls
    line_tag = "R11";
    stall_on = 1;
    setup(16, 8, 2'd0, 3'd3);
    push_lines(24'h1200, 16, 0, 8);
    go_frame(3000);
    end_lines("R11");
    chk(n_fd == 1, "R11 frame done under stall", n_fd, 1);
    stall_on = 0;

    finish_run();
  end

endmodule